// File: doc/BRIEF.md
# Flash Buffered-Program Command Decoder

This block is the device-side command engine of a NOR-style flash array that accepts buffered word programming. A host writes a short command sequence over a simple write port. The sequence is a setup command, a word count, a run of address/data loads and a confirm command. The loaded words collect in a 16-word write buffer. On a valid confirm, the block programs a behavioural array model once a fixed busy interval has elapsed. Reads go through a combinational port. That port returns either array contents or an 8-bit status byte, depending on the current read mode.

The block checks the order of the command cycles and the address combinations. It locks the target buffer on the first loaded address. Before programming, it verifies the supply-valid input, the per-block lock inputs and that the whole target buffer is erased. Every failure aborts the operation without touching the array and sets status flags. Clear-status, read-status, read-array, suspend and resume commands complete the set. Word addresses are used throughout: a buffer is address bits [ADDR_W-1:4], a page within it is bits [3:2], and the word within the page is bits [1:0]. A block is bits [ADDR_W-1:log2(BLK_WORDS)].

Top module: `flash_bufprog_ctrl`

## Requirements
- R1: After reset the array reads FFFFh everywhere, the read port is in array mode, and the status byte (after command 70h) reads 80h.
- R2: Writing E8h to any address in a block, then N (0..15) to an address in the same block, then N+1 address/data loads, then D0h programs those words; from the E8h write onward the read port returns the status byte in its low 8 bits.
- R3: For exactly BUSY_CYC cycles after an accepted confirm, status bit 7 reads 0, the low status bits read 0 and stat_hiz is 1; afterwards the status reads 80h.
- R4: Any word of the target buffer that was not loaded reads FFFFh after programming.
- R5: Only the buffer bits of the first loaded address count; later loads go to their offset (bits 3:0) inside that first buffer, and the other buffer keeps its contents.
- R6: A count above 15, a count written to a different block, a first load outside the setup block, or a confirm byte other than D0h aborts with the array unchanged and sets status bits 5 and 4 (status B0h).
- R7: Confirm to a block whose blk_lock bit is 1 aborts, leaves the array unchanged and sets bits 4 and 1 (status 92h).
- R8: vpp_ok low at the confirm write aborts and sets bits 4 and 3 (status 98h); vpp_ok is sampled only at confirm, so dropping it during busy has no effect.
- R9: Confirm to a buffer that holds any non-FFFFh word aborts with the array unchanged and sets bit 4 (status 90h); 50h does not clear it, only reset does.
- R10: Command 50h in idle clears status bits 5, 4, 3 and 1.
- R11: Command 70h selects status reads and FFh selects array reads, in idle and while suspended.
- R12: B0h during busy pauses programming, reports status 84h (ready, bit 2 set), allows array reads elsewhere; D0h then resumes, clears bit 2 and finishes the program within fewer than BUSY_CYC further cycles.
- R13: Each accepted E8h empties the write buffer, so words loaded in an aborted sequence never reach the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous-free active-low reset (sampled on clk) |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Word address of the bus write |
| wr_data | input | DATA_W | Command byte (low 8 bits), count or data of the bus write |
| rd_addr | input | ADDR_W | Word address for array reads |
| rd_data | output | DATA_W | Array word, or status byte zero-extended |
| stat_hiz | output | 1 | 1 while programming, status bits 6:0 not valid |
| vpp_ok | input | 1 | Programming supply valid, sampled at confirm |
| blk_lock | input | 2**(ADDR_W-log2(BLK_WORDS)) | Per-block write lock |

## Verification
The main function is driven with a single-page program at the first buffer, a program whose loads straddle two buffers, a one-word program at an odd offset, and a program interrupted by suspend. The first shows correct data, the exact busy length and FFFFh padding. The straddling load separates aliasing into the locked buffer from writing through to the neighbour buffer. The odd-offset program after an aborted sequence separates a freshly emptied buffer from one that keeps stale loads. The interrupted program tells a paused busy counter from a restarted or free-running one, by bounding the remaining busy time.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CNT,
    ST_LOAD,
    ST_CONF,
    ST_BUSY,
    ST_SUSP
  } fbp_state_e;

  localparam logic [7:0] CMD_SETUP   = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLRSR   = 8'h50;
  localparam logic [7:0] CMD_RDSR    = 8'h70;
  localparam logic [7:0] CMD_RDARR   = 8'hFF;
  localparam logic [7:0] CMD_SUSP    = 8'hB0;

  localparam int SR_READY = 7;
  localparam int SR_SEQ   = 5;
  localparam int SR_PROG  = 4;
  localparam int SR_VPP   = 3;
  localparam int SR_SUSP  = 2;
  localparam int SR_PROT  = 1;

endpackage

// File: rtl/fbp_wbuf.sv
module fbp_wbuf #(
  parameter int BUF_WORDS = 16,
  parameter int DATA_W    = 16,
  localparam int OFF_W    = $clog2(BUF_WORDS)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               clr,
  input  logic                               ld,
  input  logic [OFF_W-1:0]                   ld_off,
  input  logic [DATA_W-1:0]                  ld_data,
  output logic [BUF_WORDS-1:0][DATA_W-1:0]   data_o,
  output logic [BUF_WORDS-1:0]               valid_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_o  <= '0;
      valid_o <= '0;
    end else if (clr) begin
      valid_o <= '0;
    end else if (ld) begin
      data_o[ld_off]  <= ld_data;
      valid_o[ld_off] <= 1'b1;
    end
  end

endmodule

// File: rtl/fbp_array.sv
module fbp_array #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int BUF_WORDS = 16,
  localparam int OFF_W    = $clog2(BUF_WORDS),
  localparam int BIDX_W   = ADDR_W - OFF_W,
  localparam int DEPTH    = 1 << ADDR_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              prog_en,
  input  logic [BIDX_W-1:0]                 prog_buf,
  input  logic [BUF_WORDS-1:0][DATA_W-1:0]  wb_data,
  input  logic [BUF_WORDS-1:0]              wb_valid,
  input  logic [BIDX_W-1:0]                 chk_buf,
  input  logic [ADDR_W-1:0]                 rd_addr,
  output logic [DATA_W-1:0]                 rd_word,
  output logic                              chk_erased
);

  logic [DATA_W-1:0] mem [DEPTH];

  function automatic logic [ADDR_W-1:0] word_addr(input logic [BIDX_W-1:0] b, input int off);
    return {b, OFF_W'(off)};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (prog_en) begin
      for (int j = 0; j < BUF_WORDS; j++)
        mem[word_addr(prog_buf, j)] <= wb_valid[j] ? wb_data[j] : '1;
    end
  end

  always_comb begin
    chk_erased = 1'b1;
    for (int k = 0; k < BUF_WORDS; k++)
      if (mem[word_addr(chk_buf, k)] != '1) chk_erased = 1'b0;
  end

  assign rd_word = mem[rd_addr];

endmodule

// File: rtl/fbp_status.sv
module fbp_status
  import fbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       susp,
  input  logic       ev_seq_err,
  input  logic       ev_prot_err,
  input  logic       ev_vpp_err,
  input  logic       ev_dirty_err,
  input  logic       ev_clr,
  output logic       hard_q,
  output logic [7:0] sr
);

  logic seq_q, prog_q, vpp_q, prot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q  <= 1'b0;
      prog_q <= 1'b0;
      vpp_q  <= 1'b0;
      prot_q <= 1'b0;
      hard_q <= 1'b0;
    end else begin
      if (ev_clr) begin
        seq_q  <= 1'b0;
        prog_q <= 1'b0;
        vpp_q  <= 1'b0;
        prot_q <= 1'b0;
      end
      if (ev_seq_err)   begin seq_q  <= 1'b1; prog_q <= 1'b1; end
      if (ev_prot_err)  begin prot_q <= 1'b1; prog_q <= 1'b1; end
      if (ev_vpp_err)   begin vpp_q  <= 1'b1; prog_q <= 1'b1; end
      if (ev_dirty_err) hard_q <= 1'b1;
    end
  end

  always_comb begin
    sr = '0;
    if (!busy) begin
      sr[SR_READY] = 1'b1;
      sr[SR_SEQ]   = seq_q;
      sr[SR_PROG]  = prog_q | hard_q;
      sr[SR_VPP]   = vpp_q;
      sr[SR_SUSP]  = susp;
      sr[SR_PROT]  = prot_q;
    end
  end

endmodule

// File: rtl/fbp_seq.sv
module fbp_seq
  import fbp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int BUF_WORDS = 16,
  parameter int BLK_WORDS = 64,
  parameter int BUSY_CYC  = 24,
  localparam int OFF_W    = $clog2(BUF_WORDS),
  localparam int BLK_SH   = $clog2(BLK_WORDS),
  localparam int BIDX_W   = ADDR_W - OFF_W,
  localparam int KIDX_W   = ADDR_W - BLK_SH,
  localparam int NUM_BLK  = 1 << KIDX_W,
  localparam int CNT_W    = $clog2(BUSY_CYC) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                vpp_ok,
  input  logic [NUM_BLK-1:0]  blk_lock,
  input  logic                buf_erased,
  output logic                busy,
  output logic                susp,
  output logic                stat_mode,
  output logic [BIDX_W-1:0]   buf_q,
  output logic [OFF_W-1:0]    ld_off,
  output logic                ev_setup,
  output logic                ev_load,
  output logic                ev_clr,
  output logic                ev_seq_err,
  output logic                ev_prot_err,
  output logic                ev_vpp_err,
  output logic                ev_dirty_err,
  output logic                ev_start,
  output logic                ev_done,
  output logic                ev_susp,
  output logic                ev_resume
);

  function automatic logic [BIDX_W-1:0] buf_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] off_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic [KIDX_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:BLK_SH];
  endfunction

  fbp_state_e        st;
  logic [KIDX_W-1:0] blk_q;
  logic              first_q;
  logic [OFF_W-1:0]  left_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [7:0]        cmd;
  logic              cnt_bad, load_bad, conf_ok, conf_bad, mode_rd_sr, mode_rd_arr;

  assign cmd    = wr_data[7:0];
  assign ld_off = off_of(wr_addr);
  assign busy   = (st == ST_BUSY);
  assign susp   = (st == ST_SUSP);

  assign ev_setup = wr_en && st == ST_IDLE && cmd == CMD_SETUP;
  assign ev_clr   = wr_en && st == ST_IDLE && cmd == CMD_CLRSR;
  assign cnt_bad  = wr_en && st == ST_CNT &&
                    (wr_data > DATA_W'(BUF_WORDS - 1) || blk_of(wr_addr) != blk_q);
  assign load_bad = wr_en && st == ST_LOAD && first_q && blk_of(wr_addr) != blk_q;
  assign ev_load  = wr_en && st == ST_LOAD && !load_bad;
  assign conf_ok  = wr_en && st == ST_CONF && cmd == CMD_CONFIRM;
  assign conf_bad = wr_en && st == ST_CONF && cmd != CMD_CONFIRM;

  assign ev_seq_err   = cnt_bad || load_bad || conf_bad;
  assign ev_vpp_err   = conf_ok && !vpp_ok;
  assign ev_prot_err  = conf_ok && vpp_ok && blk_lock[blk_q];
  assign ev_dirty_err = conf_ok && vpp_ok && !blk_lock[blk_q] && !buf_erased;
  assign ev_start     = conf_ok && vpp_ok && !blk_lock[blk_q] && buf_erased;

  assign ev_done   = busy && cnt_q == CNT_W'(BUSY_CYC - 1);
  assign ev_susp   = wr_en && busy && cmd == CMD_SUSP && !ev_done;
  assign ev_resume = wr_en && susp && cmd == CMD_CONFIRM;

  assign mode_rd_sr  = wr_en && (st == ST_IDLE || st == ST_SUSP) && cmd == CMD_RDSR;
  assign mode_rd_arr = wr_en && (st == ST_IDLE || st == ST_SUSP) && cmd == CMD_RDARR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      blk_q     <= '0;
      buf_q     <= '0;
      first_q   <= 1'b0;
      left_q    <= '0;
      cnt_q     <= '0;
      stat_mode <= 1'b0;
    end else begin
      if (mode_rd_sr || ev_setup || ev_resume) stat_mode <= 1'b1;
      else if (mode_rd_arr)                    stat_mode <= 1'b0;
      unique case (st)
        ST_IDLE: if (ev_setup) begin
          st    <= ST_CNT;
          blk_q <= blk_of(wr_addr);
        end
        ST_CNT: if (wr_en) begin
          if (cnt_bad) st <= ST_IDLE;
          else begin
            st      <= ST_LOAD;
            left_q  <= wr_data[OFF_W-1:0];
            first_q <= 1'b1;
          end
        end
        ST_LOAD: if (load_bad) st <= ST_IDLE;
          else if (ev_load) begin
            first_q <= 1'b0;
            if (first_q) buf_q <= buf_of(wr_addr);
            if (left_q == '0) st <= ST_CONF;
            else left_q <= left_q - 1'b1;
          end
        ST_CONF: if (wr_en) begin
          if (ev_start) begin
            st    <= ST_BUSY;
            cnt_q <= '0;
          end else st <= ST_IDLE;
        end
        ST_BUSY: if (ev_done) st <= ST_IDLE;
          else if (ev_susp) st <= ST_SUSP;
          else cnt_q <= cnt_q + 1'b1;
        ST_SUSP: if (ev_resume) st <= ST_BUSY;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_bufprog_ctrl.sv
module flash_bufprog_ctrl #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int BUF_WORDS = 16,
  parameter int BLK_WORDS = 64,
  parameter int BUSY_CYC  = 24,
  localparam int OFF_W    = $clog2(BUF_WORDS),
  localparam int BIDX_W   = ADDR_W - OFF_W,
  localparam int NUM_BLK  = 1 << (ADDR_W - $clog2(BLK_WORDS))
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               stat_hiz,
  input  logic               vpp_ok,
  input  logic [NUM_BLK-1:0] blk_lock
);

  logic busy, susp, stat_mode, buf_erased, hard_q;
  logic [BIDX_W-1:0] buf_q;
  logic [OFF_W-1:0]  ld_off;
  logic ev_setup, ev_load, ev_clr, ev_seq_err, ev_prot_err, ev_vpp_err;
  logic ev_dirty_err, ev_start, ev_done, ev_susp, ev_resume;
  logic [BUF_WORDS-1:0][DATA_W-1:0] wb_data;
  logic [BUF_WORDS-1:0]             wb_valid;
  logic [DATA_W-1:0] arr_word;
  logic [7:0]        sr_w;

  fbp_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS),
    .BLK_WORDS(BLK_WORDS), .BUSY_CYC(BUSY_CYC)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vpp_ok(vpp_ok), .blk_lock(blk_lock), .buf_erased(buf_erased),
    .busy(busy), .susp(susp), .stat_mode(stat_mode), .buf_q(buf_q), .ld_off(ld_off),
    .ev_setup(ev_setup), .ev_load(ev_load), .ev_clr(ev_clr), .ev_seq_err(ev_seq_err),
    .ev_prot_err(ev_prot_err), .ev_vpp_err(ev_vpp_err), .ev_dirty_err(ev_dirty_err),
    .ev_start(ev_start), .ev_done(ev_done), .ev_susp(ev_susp), .ev_resume(ev_resume)
  );

  fbp_wbuf #(.BUF_WORDS(BUF_WORDS), .DATA_W(DATA_W)) wbuf_i (
    .clk(clk), .rst_n(rst_n), .clr(ev_setup), .ld(ev_load), .ld_off(ld_off),
    .ld_data(wr_data), .data_o(wb_data), .valid_o(wb_valid)
  );

  fbp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS)) arr_i (
    .clk(clk), .rst_n(rst_n), .prog_en(ev_done), .prog_buf(buf_q),
    .wb_data(wb_data), .wb_valid(wb_valid), .chk_buf(buf_q), .rd_addr(rd_addr),
    .rd_word(arr_word), .chk_erased(buf_erased)
  );

  fbp_status stat_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .susp(susp), .ev_seq_err(ev_seq_err),
    .ev_prot_err(ev_prot_err), .ev_vpp_err(ev_vpp_err), .ev_dirty_err(ev_dirty_err),
    .ev_clr(ev_clr), .hard_q(hard_q), .sr(sr_w)
  );

  assign rd_data  = stat_mode ? {{(DATA_W-8){1'b0}}, sr_w} : arr_word;
  assign stat_hiz = busy;

endmodule

// File: rtl/fbp_checker.sv
module fbp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] sr,
  input logic       busy,
  input logic       hard_q,
  input logic       ev_seq_err,
  input logic       ev_prot_err,
  input logic       ev_vpp_err,
  input logic       ev_dirty_err,
  input logic       ev_clr,
  input logic       ev_start,
  input logic       ev_done,
  input logic       ev_susp
);

  assert_seq_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_seq_err |=> (sr[5] && sr[4] && sr[7]));

  assert_abort_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_start, ev_seq_err, ev_prot_err, ev_vpp_err, ev_dirty_err}));

  assert_prot_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prot_err |=> (sr[1] && sr[4] && sr[7]));

  assert_vpp_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vpp_err |=> (sr[3] && sr[4]));

  assert_dirty_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dirty_err |=> (sr[4] && !busy));

  assert_dirty_survives_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clr && hard_q) |=> sr[4]);

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (busy && !sr[7]));

  assert_done_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> (!busy && sr[7]));

  assert_susp_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_susp |=> (sr[7] && sr[2] && !busy));

endmodule

bind flash_bufprog_ctrl fbp_checker chk_i (
  .clk(clk), .rst_n(rst_n), .sr(sr_w), .busy(busy), .hard_q(hard_q),
  .ev_seq_err(ev_seq_err), .ev_prot_err(ev_prot_err), .ev_vpp_err(ev_vpp_err),
  .ev_dirty_err(ev_dirty_err), .ev_clr(ev_clr), .ev_start(ev_start),
  .ev_done(ev_done), .ev_susp(ev_susp)
);

// File: tb/flash_bufprog_ctrl_tb.sv
`timescale 1ns/1ps
module flash_bufprog_ctrl_tb_top;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NB = 4;
  localparam int BC = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic vpp_ok = 1'b1;
  logic [AW-1:0] wr_addr = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NB-1:0] blk_lock = '0;
  logic [DW-1:0] rd_data;
  logic stat_hiz;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flash_bufprog_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .BUF_WORDS(16), .BLK_WORDS(64), .BUSY_CYC(BC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .stat_hiz(stat_hiz), .vpp_ok(vpp_ok),
    .blk_lock(blk_lock)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    rd_addr = a;
    #1;
    chk(rd_data === exp, tag, rd_data, exp);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    #1;
    while (!rd_data[7] && n < 5000) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic hard_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic prog1(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_wr(a, 16'h00E8);
    bus_wr(a, 16'h0000);
    bus_wr(a, d);
    bus_wr(a, 16'h00D0);
  endtask

  task automatic t_reset();
    expect_rd(8'h00, 16'hFFFF, "R1 array erased");
    expect_rd(8'hFF, 16'hFFFF, "R1 array erased top");
    bus_wr(8'h00, 16'h0070);
    expect_rd(8'h00, 16'h0080, "R1 reset status");
    bus_wr(8'h00, 16'h00FF);
    expect_rd(8'h10, 16'hFFFF, "R11 back to array");
  endtask

  task automatic t_basic();
    int n;
    bus_wr(8'h00, 16'h00E8);
    expect_rd(8'h00, 16'h0080, "R2 status after setup");
    bus_wr(8'h00, 16'h0003);
    bus_wr(8'h00, 16'h0101);
    bus_wr(8'h01, 16'h0A0A);
    bus_wr(8'h02, 16'hB1B1);
    bus_wr(8'h03, 16'hCCCC);
    bus_wr(8'h00, 16'h00D0);
    #1;
    chk(stat_hiz === 1'b1 && rd_data === 16'h0000, "R3 busy status", rd_data, 16'h0000);
    wait_ready(n);
    chk(n == BC, "R3 busy length", DW'(n), DW'(BC));
    expect_rd(8'h00, 16'h0080, "R3 ready status");
    bus_wr(8'h00, 16'h00FF);
    expect_rd(8'h00, 16'h0101, "R2 word0");
    expect_rd(8'h01, 16'h0A0A, "R2 word1");
    expect_rd(8'h02, 16'hB1B1, "R2 word2");
    expect_rd(8'h03, 16'hCCCC, "R2 word3");
    expect_rd(8'h04, 16'hFFFF, "R4 pad word4");
    expect_rd(8'h0F, 16'hFFFF, "R4 pad word15");
  endtask

  task automatic t_alias();
    int n;
    bus_wr(8'h40, 16'h00E8);
    bus_wr(8'h44, 16'h0003);
    bus_wr(8'h48, 16'h1111);
    bus_wr(8'h49, 16'h2222);
    bus_wr(8'h52, 16'h3333);
    bus_wr(8'h53, 16'h4444);
    bus_wr(8'h00, 16'h00D0);
    wait_ready(n);
    bus_wr(8'h00, 16'h00FF);
    expect_rd(8'h48, 16'h1111, "R5 first buffer word8");
    expect_rd(8'h49, 16'h2222, "R5 first buffer word9");
    expect_rd(8'h42, 16'h3333, "R5 aliased word2");
    expect_rd(8'h43, 16'h4444, "R5 aliased word3");
    expect_rd(8'h52, 16'hFFFF, "R5 other buffer untouched");
    expect_rd(8'h53, 16'hFFFF, "R5 other buffer untouched");
  endtask

  task automatic t_seq_err();
    bus_wr(8'h80, 16'h00E8);
    bus_wr(8'h80, 16'h0010);
    expect_rd(8'h80, 16'h00B0, "R6 count too big");
    bus_wr(8'h00, 16'h0050);
    expect_rd(8'h80, 16'h0080, "R10 clear after seq");
    bus_wr(8'h80, 16'h00E8);
    bus_wr(8'hC0, 16'h0000);
    expect_rd(8'h80, 16'h00B0, "R6 count other block");
    bus_wr(8'h00, 16'h0050);
    bus_wr(8'h80, 16'h00E8);
    bus_wr(8'h80, 16'h0000);
    bus_wr(8'hC0, 16'h5555);
    expect_rd(8'h80, 16'h00B0, "R6 load outside block");
    bus_wr(8'h00, 16'h0050);
    bus_wr(8'h80, 16'h00E8);
    bus_wr(8'h80, 16'h0000);
    bus_wr(8'h80, 16'h7777);
    bus_wr(8'h80, 16'h0060);
    expect_rd(8'h80, 16'h00B0, "R6 bad confirm");
    bus_wr(8'h00, 16'h00FF);
    expect_rd(8'h80, 16'hFFFF, "R6 array unchanged");
    expect_rd(8'hC0, 16'hFFFF, "R6 array unchanged other");
    bus_wr(8'h00, 16'h0070);
    bus_wr(8'h00, 16'h0050);
    expect_rd(8'h00, 16'h0080, "R10 clear");
  endtask

  task automatic t_setup_clears();
    int n;
    bus_wr(8'h90, 16'h00E8);
    bus_wr(8'h90, 16'h0001);
    bus_wr(8'h90, 16'hAAAA);
    bus_wr(8'h91, 16'hBBBB);
    bus_wr(8'h90, 16'h0000);
    bus_wr(8'h00, 16'h0050);
    bus_wr(8'h90, 16'h00E8);
    bus_wr(8'h90, 16'h0000);
    bus_wr(8'h95, 16'hCCCC);
    bus_wr(8'h90, 16'h00D0);
    wait_ready(n);
    expect_rd(8'h00, 16'h0080, "R13 status ok");
    bus_wr(8'h00, 16'h00FF);
    expect_rd(8'h90, 16'hFFFF, "R13 stale word0");
    expect_rd(8'h91, 16'hFFFF, "R13 stale word1");
    expect_rd(8'h95, 16'hCCCC, "R13 new word");
  endtask

  task automatic t_prot();
    blk_lock = 4'b1000;
    prog1(8'hC0, 16'h1234);
    #1;
    chk(stat_hiz === 1'b0, "R7 no busy", {15'b0, stat_hiz}, 16'h0000);
    expect_rd(8'hC0, 16'h0092, "R7 protect status");
    bus_wr(8'h00, 16'h00FF);
    expect_rd(8'hC0, 16'hFFFF, "R7 array unchanged");
    bus_wr(8'h00, 16'h0070);
    bus_wr(8'h00, 16'h0050);
    expect_rd(8'h00, 16'h0080, "R10 clear after protect");
    blk_lock = '0;
  endtask

  task automatic t_vpp();
    int n;
    vpp_ok = 1'b0;
    prog1(8'hA0, 16'h9999);
    expect_rd(8'h00, 16'h0098, "R8 vpp status");
    bus_wr(8'h00, 16'h00FF);
    expect_rd(8'hA0, 16'hFFFF, "R8 array unchanged");
    bus_wr(8'h00, 16'h0050);
    vpp_ok = 1'b1;
    prog1(8'hB0, 16'h4242);
    vpp_ok = 1'b0;
    wait_ready(n);
    expect_rd(8'h00, 16'h0080, "R8 drop during busy ignored");
    vpp_ok = 1'b1;
    bus_wr(8'h00, 16'h00FF);
    expect_rd(8'hB0, 16'h4242, "R8 programmed");
  endtask

  task automatic t_susp();
    int n;
    prog1(8'hD0, 16'h5A5A);
    repeat (3) @(negedge clk);
    bus_wr(8'h00, 16'h00B0);
    expect_rd(8'h00, 16'h0084, "R12 suspended status");
    bus_wr(8'h00, 16'h00FF);
    expect_rd(8'h00, 16'h0101, "R12 array read in suspend");
    expect_rd(8'hD0, 16'hFFFF, "R12 not yet programmed");
    bus_wr(8'h00, 16'h0070);
    expect_rd(8'h00, 16'h0084, "R11 status in suspend");
    bus_wr(8'h00, 16'h00D0);
    #1;
    chk(rd_data === 16'h0000 && stat_hiz === 1'b1, "R12 resumed busy", rd_data, 16'h0000);
    wait_ready(n);
    chk(n > 0 && n < BC, "R12 remaining busy", DW'(n), DW'(BC - 1));
    expect_rd(8'h00, 16'h0080, "R12 bit2 cleared");
    bus_wr(8'h00, 16'h00FF);
    expect_rd(8'hD0, 16'h5A5A, "R12 programmed after resume");
  endtask

  task automatic t_dirty();
    prog1(8'h05, 16'h0001);
    expect_rd(8'h00, 16'h0090, "R9 dirty status");
    bus_wr(8'h00, 16'h0050);
    expect_rd(8'h00, 16'h0090, "R9 clear does not clear");
    bus_wr(8'h00, 16'h00FF);
    expect_rd(8'h05, 16'hFFFF, "R9 array unchanged");
    expect_rd(8'h00, 16'h0101, "R9 array unchanged word0");
    hard_reset();
    bus_wr(8'h00, 16'h0070);
    expect_rd(8'h00, 16'h0080, "R9 reset clears");
  endtask

  initial begin
    hard_reset();
    t_reset();
    t_basic();
    t_alias();
    t_seq_err();
    t_setup_clears();
    t_prot();
    t_vpp();
    t_susp();
    t_dirty();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %h expected %h", 1'b0, 1'b1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule